// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block holds the interrupt request flags and the interrupt enable mask of a small 8-bit microcontroller core, both reachable through a simple register port. Peripheral event pulses set sticky flags. Software clears a flag only by writing a zero into its bit; ones written are ignored, so software can never create a request. A flag reaches the core as an interrupt only when its mask bit is set. Masked flags remain visible for polling.

The lowest-numbered pending, unmasked flag wins. The block registers an interrupt request together with a 20-bit vector. The low 16 bits are computed from a base and a per-source stride. The upper 4 bits copy the current code-fetch bank, which entry into the interrupt leaves unchanged. Taking the interrupt does not clear the flag; the handler must clear it with an explicit write.

Flag bit 1 belongs to a low-power timer that keeps running in idle mode while the core clock is stopped. That flag lives in the always-on clock domain, so an overflow sets it with the core clock halted. A set of this flag from clear also raises a wakeup pulse, which is separate from the normal interrupt. Its value reaches the core logic through a two-flop synchronizer.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all flags and all mask bits read 0, and irq_req and wake_req are 0.
- R2: An event pulse on bit i sets flag i (register address 0xFE). Writing 0 to bit i at 0xFE clears it. Writing 1 to bit i leaves it unchanged.
- R3: Writing 0xFF to 0xFE while flags are clear leaves every flag clear, so software cannot set a flag.
- R4: An event on bit i in the same cycle as a write of 0 to bit i at 0xFE leaves flag i set.
- R5: The mask register at 0xFD reads back what was written. A flag whose mask bit is 0 reads as 1 at 0xFE but does not raise irq_req. Setting the mask bit raises irq_req.
- R6: irq_req and the flag stay asserted while the interrupt is pending. There is no implicit acknowledge; only a write of 0 clears the flag.
- R7: Among flags that are both set and unmasked, the lowest bit index wins. irq_vec[15:0] = 0x0100 + 8*index and irq_vec[19:16] = code_bank. irq_req and irq_vec are registered one cycle after the flag state.
- R8: A pulse on lp_ovf sets flag bit 1 even while the core clock is stopped. The set flag reads back once the core clock runs again.
- R9: wake_req pulses high for one aon_clk cycle when flag bit 1 goes from 0 to 1. An overflow while the flag is already set gives no wakeup.
- R10: After a wakeup, an interrupt for bit 1 is raised only when mask bit 1 is set.
- R11: Read data is registered one cycle after the address. Addresses other than 0xFD and 0xFE read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; may be stopped in idle |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| aon_clk | input | 1 | Always-on low-power clock |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_pulse | input | 8 | Peripheral event pulses; bit 1 is unused |
| lp_ovf | input | 1 | Low-power timer overflow, in the aon_clk domain |
| code_bank | input | 4 | Current code-fetch bank bits |
| irq_req | output | 1 | Registered interrupt request to the core |
| irq_vec | output | 20 | Registered vector of the winning source |
| wake_req | output | 1 | Wakeup pulse in the aon_clk domain |

## Verification
The hardest case to reach is the low-power flag being set while the core clock is halted, followed by a second overflow that must not wake the core. The bench gates its core clock off during the low phase. It pulses lp_ovf on the always-on clock and watches wake_req in that domain. It then restarts the core clock, reads the flag through the register port and sets the mask bit to confirm the separate interrupt. The clear of bit 1 crosses both domains, so the bench waits several always-on cycles before re-arming the wakeup.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BANK_W = 4;
  localparam int VLO_W  = 16;
  localparam int VEC_W  = BANK_W + VLO_W;

  function automatic logic [VLO_W-1:0] vec_low(input logic [VLO_W-1:0] base,
                                                input logic [VLO_W-1:0] stride,
                                                input logic [VLO_W-1:0] idx);
    return base + idx * stride;
  endfunction
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int N_SRC  = 8,
  parameter int LP_BIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt,
  input  logic             flag_wr,
  input  logic [N_SRC-1:0] wdata,
  input  logic             lp_in,
  output logic [N_SRC-1:0] flags
);
  logic unused_lp_evt;
  assign unused_lp_evt = evt[LP_BIT];

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    if (i == LP_BIT) begin : g_lp
      assign flags[i] = lp_in;
    end else begin : g_std
      logic f_q;
      always_ff @(posedge clk) begin
        if (rst)          f_q <= 1'b0;
        else if (evt[i])  f_q <= 1'b1;
        else if (flag_wr) f_q <= f_q & wdata[i];
      end
      assign flags[i] = f_q;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        evt[i] |=> f_q); // R4
      AST_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
        (!evt[i] && !f_q) |=> !f_q); // R3
      AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (f_q && !(flag_wr && !wdata[i])) |=> f_q); // R6
    end
  end
endmodule

// File: rtl/irqc_lp_flag.sv
module irqc_lp_flag (
  input  logic clk,
  input  logic rst,
  input  logic aon_clk,
  input  logic lp_ovf,
  input  logic clr_req,
  output logic lp_core,
  output logic wake_req
);
  logic       clr_tgl;
  logic [2:0] clr_sync;
  logic       clr_ev;
  logic       lp_flag;
  logic [1:0] lp_sync;

  always_ff @(posedge clk) begin
    if (rst)          clr_tgl <= 1'b0;
    else if (clr_req) clr_tgl <= ~clr_tgl;
  end

  always_ff @(posedge aon_clk) begin
    if (rst) clr_sync <= '0;
    else     clr_sync <= {clr_sync[1:0], clr_tgl};
  end
  assign clr_ev = clr_sync[2] ^ clr_sync[1];

  always_ff @(posedge aon_clk) begin
    if (rst) begin
      lp_flag  <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      wake_req <= lp_ovf & ~lp_flag;
      if (lp_ovf)      lp_flag <= 1'b1;
      else if (clr_ev) lp_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lp_sync <= '0;
    else     lp_sync <= {lp_sync[0], lp_flag};
  end
  assign lp_core = lp_sync[1];

  AST_LP_SET: assert property (@(posedge aon_clk) disable iff (rst)
    lp_ovf |=> lp_flag); // R8
  AST_WAKE_EDGE: assert property (@(posedge aon_clk) disable iff (rst)
    wake_req |-> $past(!lp_flag)); // R9
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
#(
  parameter int                N_SRC  = 8,
  parameter logic [VLO_W-1:0] VBASE  = 16'h0100,
  parameter logic [VLO_W-1:0] VSTEP  = 16'h0008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  pend,
  input  logic [BANK_W-1:0] code_bank,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             any;
  logic [IDX_W-1:0] win;

  always_comb begin
    any = 1'b0;
    win = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        win = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_req <= any;
      irq_vec <= {code_bank, vec_low(VBASE, VSTEP, VLO_W'(win))};
    end
  end

  AST_VEC_BANK: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> irq_vec[VEC_W-1:VLO_W] == $past(code_bank)); // R7
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
#(
  parameter int                N_SRC     = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hFE,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hFD,
  parameter int                LP_BIT    = 1,
  parameter logic [15:0]       VBASE     = 16'h0100,
  parameter logic [15:0]       VSTEP     = 16'h0008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aon_clk,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  evt_pulse,
  input  logic              lp_ovf,
  input  logic [3:0]        code_bank,
  output logic              irq_req,
  output logic [19:0]       irq_vec,
  output logic              wake_req
);
  logic             flag_wr, mask_wr;
  logic [N_SRC-1:0] flags, mask_q;
  logic             lp_core;

  assign flag_wr = bus_wr && (bus_addr == FLAG_ADDR);
  assign mask_wr = bus_wr && (bus_addr == MASK_ADDR);

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_wr) mask_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                        bus_rdata <= '0;
    else if (bus_addr == FLAG_ADDR) bus_rdata <= flags;
    else if (bus_addr == MASK_ADDR) bus_rdata <= mask_q;
    else                            bus_rdata <= '0;
  end

  irqc_lp_flag u_lp (
    .clk      (clk),
    .rst      (rst),
    .aon_clk  (aon_clk),
    .lp_ovf   (lp_ovf),
    .clr_req  (flag_wr && !bus_wdata[LP_BIT]),
    .lp_core  (lp_core),
    .wake_req (wake_req)
  );

  irqc_flag_bank #(.N_SRC(N_SRC), .LP_BIT(LP_BIT)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt_pulse),
    .flag_wr (flag_wr),
    .wdata   (bus_wdata),
    .lp_in   (lp_core),
    .flags   (flags)
  );

  irqc_prio #(.N_SRC(N_SRC), .VBASE(VBASE), .VSTEP(VSTEP)) u_prio (
    .clk       (clk),
    .rst       (rst),
    .pend      (flags & mask_q),
    .code_bank (code_bank),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec)
  );

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mask_wr |=> $stable(mask_q)); // R5
endmodule

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;
  logic clk_free = 1'b0, clk_en = 1'b1, aon_clk = 1'b0;
  logic clk;
  logic rst = 1'b1;
  logic [7:0] bus_addr = '0, bus_wdata = '0, evt_pulse = '0;
  logic bus_wr = 1'b0, lp_ovf = 1'b0;
  logic [3:0] code_bank = '0;
  logic [7:0] bus_rdata;
  logic irq_req, wake_req;
  logic [19:0] irq_vec;
  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] rv;

  always #10 clk_free = ~clk_free;
  always #35 aon_clk = ~aon_clk;
  assign clk = clk_free & clk_en;

  irq_flag_ctrl uut (
    .clk(clk), .rst(rst), .aon_clk(aon_clk), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .lp_ovf(lp_ovf),
    .code_bank(code_bank), .irq_req(irq_req), .irq_vec(irq_vec), .wake_req(wake_req));

  // evt, mask, bank, expected irq, expected vector
  localparam logic [40:0] TBL [6] = '{
    {8'h01, 8'hFF, 4'h3, 1'b1, 20'h30100},
    {8'h0C, 8'hFF, 4'h0, 1'b1, 20'h00110},
    {8'h0C, 8'hFB, 4'hA, 1'b1, 20'hA0118},
    {8'h80, 8'h7F, 4'h1, 1'b0, 20'h00000},
    {8'hF0, 8'hC0, 4'hF, 1'b1, 20'hF0130},
    {8'h00, 8'hFF, 4'h2, 1'b0, 20'h00000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_free); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk_free); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_free); bus_addr = a; bus_wr = 1'b0;
    @(negedge clk_free); d = bus_rdata;
  endtask

  task automatic evt(input logic [7:0] e);
    @(negedge clk_free); evt_pulse = e;
    @(negedge clk_free); evt_pulse = '0;
  endtask

  task automatic ovf();
    @(negedge aon_clk); lp_ovf = 1'b1;
    @(negedge aon_clk); lp_ovf = 1'b0;
  endtask

  always @(posedge clk_free) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20) @(negedge clk_free);
    // R1 reset state (checked while still in reset and just after)
    check("R1 irq_req", irq_req, 0);
    check("R1 wake_req", wake_req, 0);
    rst = 1'b0;
    rd(8'hFE, rv); check("R1 flags", rv, 8'h00);
    rd(8'hFD, rv); check("R1 mask", rv, 8'h00);

    // R7 priority / vector table
    foreach (TBL[k]) begin
      wr(8'hFE, 8'h00);
      wr(8'hFD, TBL[k][32:25]);
      code_bank = TBL[k][24:21];
      evt(TBL[k][40:33]);
      @(negedge clk_free);
      check($sformatf("R7 row%0d req", k), irq_req, TBL[k][20]);
      if (TBL[k][20]) check($sformatf("R7 row%0d vec", k), irq_vec, TBL[k][19:0]);
    end
    wr(8'hFE, 8'h00); wr(8'hFD, 8'h00);

    // R2 set, write one ignored, write zero clears
    evt(8'h10);
    rd(8'hFE, rv); check("R2 set", rv, 8'h10);
    wr(8'hFE, 8'hFF);
    rd(8'hFE, rv); check("R2 write one", rv, 8'h10);
    wr(8'hFE, 8'hEF);
    rd(8'hFE, rv); check("R2 write zero", rv, 8'h00);

    // R3 software cannot set
    wr(8'hFE, 8'hFF);
    rd(8'hFE, rv); check("R3 no set", rv, 8'h00);

    // R4 event wins over simultaneous clear
    evt(8'h08);
    @(negedge clk_free); bus_addr = 8'hFE; bus_wdata = 8'h00; bus_wr = 1'b1; evt_pulse = 8'h08;
    @(negedge clk_free); bus_wr = 1'b0; evt_pulse = '0;
    rd(8'hFE, rv); check("R4 set wins", rv, 8'h08);
    wr(8'hFE, 8'h00);

    // R5 masked flag polled, no irq; unmask raises irq
    evt(8'h20);
    rd(8'hFD, rv); check("R5 mask readback", rv, 8'h00);
    rd(8'hFE, rv); check("R5 polled", rv, 8'h20);
    check("R5 masked no irq", irq_req, 0);
    wr(8'hFD, 8'h20);
    @(negedge clk_free);
    check("R5 unmasked irq", irq_req, 1);
    // R6 no implicit acknowledge
    repeat (5) @(negedge clk_free);
    check("R6 irq held", irq_req, 1);
    rd(8'hFE, rv); check("R6 flag held", rv, 8'h20);
    wr(8'hFE, 8'h00); wr(8'hFD, 8'h00);
    @(negedge clk_free);
    check("R6 irq drops after clear", irq_req, 0);

    // R11 other address reads zero
    rd(8'h10, rv); check("R11 other addr", rv, 8'h00);

    // R8/R9/R10 low-power flag with core clock stopped
    code_bank = 4'h5;
    @(negedge clk_free); clk_en = 1'b0;
    ovf();
    check("R9 wake pulse", wake_req, 1);
    @(negedge aon_clk);
    check("R9 wake one cycle", wake_req, 0);
    @(negedge clk_free); clk_en = 1'b1;
    repeat (4) @(negedge clk_free);
    rd(8'hFE, rv); check("R8 set while stopped", rv, 8'h02);
    check("R10 masked no irq", irq_req, 0);
    wr(8'hFD, 8'h02);
    @(negedge clk_free);
    check("R10 irq with mask", irq_req, 1);
    check("R10 vec", irq_vec, 20'h50108);
    // second overflow while already set: no wakeup
    ovf();
    check("R9 no wake when set", wake_req, 0);
    @(negedge aon_clk);
    check("R9 no wake later", wake_req, 0);
    // clear bit 1 across domains, then re-arm
    wr(8'hFE, 8'h00);
    repeat (8) @(negedge aon_clk);
    rd(8'hFE, rv); check("R2 lp clear", rv, 8'h00);
    ovf();
    check("R9 wake re-armed", wake_req, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule